// File: doc/BRIEF.md
# Asynchronous Handshake Read Master (16-bit data path)

This block runs read cycles on a bus that has no shared clock. An internal requester gives it a byte address, a transfer size and a one-cycle start pulse. The controller drives a word address, an address strobe, and separate strobes for the upper and lower byte lanes. It waits until the slave acknowledges, then captures the returned data and hands back a right-aligned result with a one-cycle done pulse.

Every output toward the bus comes from a register. The acknowledge and the data coming back from the slave each pass through a synchronizer chain before the controller uses them. A cycle moves through six steps in order: drive the address with the address strobe, assert the data strobes, wait for the acknowledge, latch the data one synchronized cycle later, negate all strobes, and wait for the slave to release its acknowledge.

A long-word read is made of two word cycles back to back. The second of these cycles uses the next word address.

Top module: `abus_rd_master`

## Requirements
- R1: After reset, `bus_as_n`, `bus_uds_n` and `bus_lds_n` are high (negated), and `busy` and `done` are low.
- R2: For `req_size` = 1 (word), both lane strobes are asserted together and `result` = {16'h0000, bus_data[15:8], bus_data[7:0]}. Address bit 0 is ignored for word and long reads.
- R3: For `req_size` = 0 (byte) with `req_addr[0]` = 0, only `bus_uds_n` is asserted, and `result` = {24'h0, bus_data[15:8]}.
- R4: For `req_size` = 0 (byte) with `req_addr[0]` = 1, only `bus_lds_n` is asserted, and `result` = {24'h0, bus_data[7:0]}.
- R5: `bus_addr` equals `req_addr[AW:1]` and stays stable while `bus_as_n` is asserted.
- R6: The address strobe is asserted at least one cycle before the lane strobes. Lane strobes are asserted only while the address strobe is asserted. The strobes stay asserted, and `done` stays low, for as long as `bus_dtack_n` is high. The strobes are negated only after the acknowledge has been seen.
- R7: For `req_size` = 2 or 3 (long), two word cycles run. The first uses word address `req_addr[AW:1]` and the second uses that address plus 1. The first word goes to `result[31:16]` and the second word to `result[15:0]`.
- R8: The address strobe of a new cycle is asserted only after the slave has released `bus_dtack_n` high.
- R9: A `req_start` pulse that arrives while `busy` is high has no effect. It starts no bus cycle and does not change the result.
- R10: `busy` goes high in the cycle after an accepted start and falls in the same cycle that `done` pulses. `done` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | One-cycle request pulse |
| req_addr | input | AW+1 | Byte address of the read |
| req_size | input | 2 | 0 byte, 1 word, 2/3 long |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Right-aligned read data |
| bus_addr | output | AW | Word address (byte address bits AW:1) |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper lane (bits 15:8) strobe, active low |
| bus_lds_n | output | 1 | Lower lane (bits 7:0) strobe, active low |
| bus_dtack_n | input | 1 | Slave acknowledge, active low, asynchronous |
| bus_data | input | 16 | Read data from the slave |

## Verification
The assertions assume that a well-behaved slave keeps `bus_dtack_n` low until it sees the address strobe negated. They also assume the slave keeps `bus_data` steady for as long as its acknowledge is asserted. The bench slave model is built to follow both rules. It uses a programmable acknowledge delay and a programmable release delay, and it never raises or lowers its acknowledge in any other way. The model also never pulses `req_start` during reset.

// File: rtl/abus_rd_master.sv
module abus_rd_master #(
  parameter int AW   = 23,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_start,
  input  logic [AW:0]   req_addr,
  input  logic [1:0]    req_size,
  output logic          busy,
  output logic          done,
  output logic [31:0]   result,
  output logic [AW:1]   bus_addr,
  output logic          bus_as_n,
  output logic          bus_uds_n,
  output logic          bus_lds_n,
  input  logic          bus_dtack_n,
  input  logic [15:0]   bus_data
);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_STROBE, S_WAIT, S_LATCH, S_NEG, S_REL
  } st_t;

  st_t state, nxt;
  logic [SYNC-1:0]       ack_pipe;
  logic [SYNC-1:0][15:0] dat_pipe;
  logic ack_s, is_byte, is_long, second, a0;
  logic [15:0] dat_s;

  assign ack_s = ack_pipe[SYNC-1];
  assign dat_s = dat_pipe[SYNC-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_pipe <= '0;
      dat_pipe <= '0;
    end else begin
      ack_pipe <= {ack_pipe[SYNC-2:0], ~bus_dtack_n};
      dat_pipe <= {dat_pipe[SYNC-2:0], bus_data};
    end
  end

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:   if (req_start) nxt = S_ADDR;
      S_ADDR:   nxt = S_STROBE;
      S_STROBE: nxt = S_WAIT;
      S_WAIT:   if (ack_s) nxt = S_LATCH;
      S_LATCH:  nxt = S_NEG;
      S_NEG:    nxt = S_REL;
      S_REL:    if (!ack_s) nxt = (is_long && !second) ? S_ADDR : S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  wire as_on = (nxt == S_ADDR) || (nxt == S_STROBE) || (nxt == S_WAIT) || (nxt == S_LATCH);
  wire ds_on = (nxt == S_STROBE) || (nxt == S_WAIT) || (nxt == S_LATCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      bus_as_n  <= 1'b1;
      bus_uds_n <= 1'b1;
      bus_lds_n <= 1'b1;
      bus_addr  <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      result    <= '0;
      is_byte   <= 1'b0;
      is_long   <= 1'b0;
      second    <= 1'b0;
      a0        <= 1'b0;
    end else begin
      state     <= nxt;
      done      <= 1'b0;
      bus_as_n  <= ~as_on;
      bus_uds_n <= ~(ds_on && (!is_byte || !a0));
      bus_lds_n <= ~(ds_on && (!is_byte || a0));
      case (state)
        S_IDLE: if (req_start) begin
          bus_addr <= req_addr[AW:1];
          a0       <= req_addr[0];
          is_byte  <= (req_size == 2'd0);
          is_long  <= req_size[1];
          second   <= 1'b0;
          busy     <= 1'b1;
        end
        S_LATCH: begin
          if (is_byte)               result <= {24'h0, a0 ? dat_s[7:0] : dat_s[15:8]};
          else if (!is_long)         result <= {16'h0, dat_s};
          else if (!second)          result[31:16] <= dat_s;
          else                       result[15:0]  <= dat_s;
        end
        S_REL: if (!ack_s) begin
          if (is_long && !second) begin
            second   <= 1'b1;
            bus_addr <= bus_addr + 1'b1;
          end else begin
            done <= 1'b1;
            busy <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/abus_rd_master_chk.sv
module abus_rd_master_chk #(
  parameter int AW = 23
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [AW:1] bus_addr,
  input logic        bus_as_n,
  input logic        bus_uds_n,
  input logic        bus_lds_n,
  input logic        bus_dtack_n
);

  assert_ds_within_as_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_uds_n || !bus_lds_n) |-> !bus_as_n);

  assert_as_leads_ds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_as_n) |-> (bus_uds_n && bus_lds_n));

  assert_negate_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_as_n) |-> !$past(bus_dtack_n));

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as_n && !$past(bus_as_n)) |-> $stable(bus_addr));

  assert_new_cycle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_as_n) |-> $past(bus_dtack_n));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

bind abus_rd_master abus_rd_master_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .bus_addr(bus_addr),
  .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n),
  .bus_dtack_n(bus_dtack_n)
);

// File: tb/abus_rd_master_tb.sv
`timescale 1ns/1ps
module abus_rd_master_tb;
  localparam int AW = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_start = 1'b0;
  logic [AW:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic busy, done;
  logic [31:0] result;
  logic [AW:1] bus_addr;
  logic bus_as_n, bus_uds_n, bus_lds_n;
  logic bus_dtack_n = 1'b1;
  logic [15:0] bus_data = '0;

  always #4 clk = ~clk;

  abus_rd_master #(.AW(AW), .SYNC(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
    .req_size(req_size), .busy(busy), .done(done), .result(result),
    .bus_addr(bus_addr), .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n),
    .bus_lds_n(bus_lds_n), .bus_dtack_n(bus_dtack_n), .bus_data(bus_data)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  function automatic logic [15:0] wfn(input logic [AW:1] wa);
    return {wa[8:1] ^ 8'h5A, ~wa[8:1] + wa[16:9]};
  endfunction

  int ack_delay = 0;
  int rel_delay = 0;
  int acnt = 0;
  int rcnt = 0;
  int n_as = 0;
  int n_ack = 0;
  int viol_rel = 0;
  int viol_lead = 0;
  logic as_prev = 1'b1;
  logic [AW:1] log_addr [4];
  logic [1:0]  log_strb [4];

  always @(negedge clk) begin
    if (!rst_n) begin
      bus_dtack_n <= 1'b1;
      acnt <= 0;
      rcnt <= 0;
      as_prev <= 1'b1;
    end else begin
      as_prev <= bus_as_n;
      if (as_prev && !bus_as_n) begin
        n_as <= n_as + 1;
        if (!bus_dtack_n) viol_rel <= viol_rel + 1;
        if (!bus_uds_n || !bus_lds_n) viol_lead <= viol_lead + 1;
      end
      if (!bus_as_n && (!bus_uds_n || !bus_lds_n)) begin
        if (bus_dtack_n) begin
          if (acnt >= ack_delay) begin
            bus_dtack_n <= 1'b0;
            bus_data <= wfn(bus_addr);
            log_addr[n_ack[1:0]] <= bus_addr;
            log_strb[n_ack[1:0]] <= {bus_uds_n, bus_lds_n};
            n_ack <= n_ack + 1;
            acnt <= 0;
          end else acnt <= acnt + 1;
        end
      end else if (bus_as_n && !bus_dtack_n) begin
        if (rcnt >= rel_delay) begin
          bus_dtack_n <= 1'b1;
          bus_data <= 16'hxxxx;
          rcnt <= 0;
        end else rcnt <= rcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [AW:0] a, input logic [1:0] s);
    @(negedge clk);
    req_addr = a;
    req_size = s;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int t = 0;
    ok = 1'b0;
    while (t < 600) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
      t++;
    end
  endtask

  task automatic run(input logic [AW:0] a, input logic [1:0] s, input int ad, input int rd);
    int base_ack;
    int nexp;
    bit ok;
    logic [AW:1] wa;
    logic [31:0] exp;
    logic [1:0] sexp;
    wa = a[AW:1];
    ack_delay = ad;
    rel_delay = rd;
    base_ack = n_ack;
    nexp = s[1] ? 2 : 1;
    if (s == 2'd0) begin
      exp  = {24'h0, a[0] ? wfn(wa)[7:0] : wfn(wa)[15:8]};
      sexp = a[0] ? 2'b10 : 2'b01;
    end else if (!s[1]) begin
      exp  = {16'h0, wfn(wa)};
      sexp = 2'b00;
    end else begin
      exp  = {wfn(wa), wfn(wa + 1'b1)};
      sexp = 2'b00;
    end
    pulse_start(a, s);
    chk(busy === 1'b1, "R10 busy after start", {31'h0, busy}, 32'h1);
    wait_done(ok);
    chk(ok, "R10 done seen", {31'h0, ok}, 32'h1);
    chk(busy === 1'b0, "R10 busy drops with done", {31'h0, busy}, 32'h0);
    chk(result === exp, s == 0 ? (a[0] ? "R4 byte odd data" : "R3 byte even data")
                        : (s[1] ? "R7 long data" : "R2 word data"), result, exp);
    chk(n_ack - base_ack == nexp, "R7 cycle count", n_ack - base_ack, nexp);
    chk(log_strb[base_ack[1:0]] === sexp, s == 0 ? (a[0] ? "R4 lane strobes" : "R3 lane strobes")
                                                : "R2 lane strobes",
        {30'h0, log_strb[base_ack[1:0]]}, {30'h0, sexp});
    chk(log_addr[base_ack[1:0]] === wa, "R5 word address", log_addr[base_ack[1:0]], wa);
    if (s[1]) begin
      chk(log_addr[base_ack[1:0] + 2'd1] === wa + 1'b1, "R7 second address",
          log_addr[base_ack[1:0] + 2'd1], wa + 1'b1);
      chk(log_strb[base_ack[1:0] + 2'd1] === 2'b00, "R7 second strobes",
          {30'h0, log_strb[base_ack[1:0] + 2'd1]}, 32'h0);
    end
    @(negedge clk);
    chk(done === 1'b0, "R10 done one cycle", {31'h0, done}, 32'h0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({bus_as_n, bus_uds_n, bus_lds_n} === 3'b111, "R1 strobes in reset",
        {29'h0, bus_as_n, bus_uds_n, bus_lds_n}, 32'h7);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done} === 2'b00, "R1 busy/done after reset", {30'h0, busy, done}, 32'h0);
    chk({bus_as_n, bus_uds_n, bus_lds_n} === 3'b111, "R1 strobes after reset",
        {29'h0, bus_as_n, bus_uds_n, bus_lds_n}, 32'h7);

    for (int d = 0; d < 3; d++)
      for (int sz = 0; sz < 4; sz++)
        for (int ad = 0; ad < 16; ad++)
          run({ad[7:0] * 8'd37 + 8'h40, 16'h0} >> 16 | (AW+1)'(ad * 1031 + d * 517),
              sz[1:0], d * 2, (d == 2) ? 3 : d);

    begin : stall_r6
      bit ok;
      ack_delay = 40;
      rel_delay = 0;
      pulse_start(24'h000124, 2'd1);
      repeat (25) @(negedge clk);
      chk({bus_as_n, bus_uds_n, bus_lds_n} === 3'b000, "R6 strobes held without ack",
          {29'h0, bus_as_n, bus_uds_n, bus_lds_n}, 32'h0);
      chk(done === 1'b0, "R6 no done without ack", {31'h0, done}, 32'h0);
      wait_done(ok);
      chk(ok && result === {16'h0, wfn(23'h92)}, "R6 completes after ack", result, {16'h0, wfn(23'h92)});
    end

    begin : ignore_r9
      bit ok;
      int base_as;
      ack_delay = 6;
      rel_delay = 2;
      @(negedge clk);
      base_as = n_as;
      pulse_start(24'h000301, 2'd0);
      repeat (4) @(negedge clk);
      pulse_start(24'h000A00, 2'd2);
      wait_done(ok);
      chk(ok && result === {24'h0, wfn(23'h180)[7:0]}, "R9 result unaffected", result,
          {24'h0, wfn(23'h180)[7:0]});
      repeat (20) @(negedge clk);
      chk(n_as - base_as == 1, "R9 no extra bus cycle", n_as - base_as, 1);
      chk(busy === 1'b0, "R9 idle after ignored start", {31'h0, busy}, 32'h0);
    end

    chk(viol_rel == 0, "R8 address strobe only after release", viol_rel, 0);
    chk(viol_lead == 0, "R6 address strobe leads lane strobes", viol_lead, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule